// File: doc/BRIEF.md
# Register Message Bus Requester

This block sits on the requesting end of a narrow register bus that shares eight wires in each direction between commands, addresses and data. A local client hands it one register access at a time over a valid/ready port: a read, a write that is only staged at the far end (uncommitted), or a write that makes all staged writes take effect together (committed). The block turns each access into a short burst of byte-wide beats on the outbound bus and drives an all-zero NOP beat whenever it has nothing to send.

On the inbound bus it looks for two kinds of answer. A write acknowledge releases the stall that every committed write imposes. A read completion carries the byte the last read asked for, which goes back to the client with a one-cycle valid pulse. Only one read may be in flight at a time. Writes may still go out while a read is outstanding. If an answer never comes, a watchdog releases the wait after a fixed number of cycles and sets an error flag that stays set until reset.

Top module: `mbus_initiator`

## Requirements
- R1: After reset the outbound bus is 0x00, `req_ready` is high for a read request, `rsp_valid` is low and `err_timeout` is low.
- R2: The request kind is encoded as 0 = read, 1 = uncommitted write, 2 = committed write. An accepted request appears on `mb_out` starting in the cycle after the handshake. Beat 0 is {command, addr[11:8]}, where the command in bits 7:4 is 3 for a read, 1 for an uncommitted write and 2 for a committed write. Beat 1 is addr[7:0]. Writes add beat 2, which is the write data. All beats go out on consecutive cycles.
- R3: In every cycle that carries no beat of a request, `mb_out` is 0x00 (NOP).
- R4: An uncommitted write does not stall. `req_ready` is high again in the cycle its last beat is on the bus.
- R5: After a committed write is accepted, `req_ready` stays low for every request kind until an inbound beat with bits 7:4 equal to 5 (write acknowledge) has been seen. It is high in the cycle after that beat.
- R6: An inbound beat with bits 7:4 equal to 4 (read completion) is followed on the next cycle by the data byte. `rsp_valid` is high for exactly one cycle, the cycle after the data byte, with `rsp_data` equal to that byte.
- R7: While a read is outstanding, a new read is not accepted, but uncommitted and committed writes are.
- R8: The data byte of a read completion is never taken as a write acknowledge, even if its upper nibble is 5. A completion that arrives with no read outstanding produces no `rsp_valid`.
- R9: If a write acknowledge or read completion has not arrived within 64 cycles of the request being accepted, the wait is released and `err_timeout` goes high in the cycle after the 64th edge. It then stays high until reset.
- R10: Request kind 3 is never accepted: `req_ready` is low and nothing is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_kind | input | 2 | 0 read, 1 uncommitted write, 2 committed write |
| req_addr | input | 12 | Register address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_data | output | 8 | Read data |
| mb_out | output | 8 | Outbound bus beats |
| mb_in | input | 8 | Inbound bus beats |
| err_timeout | output | 1 | Sticky missing-answer error |

## Verification
Some properties are checked by assertions on every cycle. These are: the ready stall after a committed write, the single-read limit, the refusal of kind 3, NOP after an idle cycle, a legal command nibble in the first beat, the single-cycle read pulse, and the sticky error. The bench scenarios are needed for the rest. They check the exact beat contents and their order. They check that the stall is released precisely one cycle after the acknowledge. They check that a completion byte that looks like an acknowledge does not release a pending committed write. They check that unsolicited completions are dropped. They check that the error rises on the exact cycle set by the 64-cycle limit.

// File: rtl/mbus_init_pkg.sv
`timescale 1ns/1ps
package mbus_init_pkg;
    localparam int BEAT_W = 8;
    localparam int CMD_W  = 4;
    localparam int ADDR_W = 12;
    localparam int HI_W   = ADDR_W - BEAT_W;

    typedef enum logic [CMD_W-1:0] {
        CMD_NOP    = 4'h0,
        CMD_WR_UNC = 4'h1,
        CMD_WR_COM = 4'h2,
        CMD_RD     = 4'h3,
        CMD_RD_CPL = 4'h4,
        CMD_WR_ACK = 4'h5
    } mb_cmd_e;

    typedef enum logic [1:0] {
        KIND_RD     = 2'd0,
        KIND_WR_UNC = 2'd1,
        KIND_WR_COM = 2'd2,
        KIND_BAD    = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BEAT1 = 2'd1,
        ST_BEAT2 = 2'd2
    } tx_state_e;

    typedef struct packed {
        tx_state_e         state;
        logic [BEAT_W-1:0] bus;
        logic [ADDR_W-1:0] addr;
        logic [BEAT_W-1:0] wdata;
        logic              is_wr;
        logic              wait_ack;
        logic              wait_cpl;
        logic              rsp_valid;
        logic [BEAT_W-1:0] rsp_data;
        logic              err;
    } init_reg_t;
endpackage

// File: rtl/mbus_rx_parse.sv
`timescale 1ns/1ps
module mbus_rx_parse
    import mbus_init_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BEAT_W-1:0] mb_in,
    output logic              ack_fire,
    output logic              cpl_fire,
    output logic [BEAT_W-1:0] cpl_data
);
    logic             expect_d, expect_q;
    logic [CMD_W-1:0] cmd;

    always_comb begin
        cmd      = mb_in[BEAT_W-1 -: CMD_W];
        cpl_fire = expect_q;
        cpl_data = mb_in;
        ack_fire = !expect_q && (cmd == CMD_WR_ACK);
        expect_d = !expect_q && (cmd == CMD_RD_CPL);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) expect_q <= 1'b0;
        else        expect_q <= expect_d;
    end
endmodule

// File: rtl/mbus_wdog.sv
`timescale 1ns/1ps
module mbus_wdog #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    output logic expire_o
);
    localparam int CNT_W = $clog2(LIMIT);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        expire_o = arm_i && (cnt_q == LAST);
        cnt_d    = (arm_i && !expire_o) ? cnt_q + 1'b1 : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R9: an expiry is a single event; the wait it guards is dropped at once
    assert_expire_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> !expire_o);
endmodule

// File: rtl/mbus_initiator.sv
`timescale 1ns/1ps
module mbus_initiator
    import mbus_init_pkg::*;
#(
    parameter int TIMEOUT = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BEAT_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [BEAT_W-1:0] rsp_data,
    output logic [BEAT_W-1:0] mb_out,
    input  logic [BEAT_W-1:0] mb_in,
    output logic              err_timeout
);
    localparam int N_WAIT = 2;   // index 0: write ack, index 1: read completion

    init_reg_t          d, q;
    logic               accept;
    logic               ack_fire, cpl_fire;
    logic [BEAT_W-1:0]  cpl_data;
    logic [N_WAIT-1:0]  wd_arm, wd_expire;
    mb_cmd_e            tx_cmd;

    mbus_rx_parse u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .mb_in    (mb_in),
        .ack_fire (ack_fire),
        .cpl_fire (cpl_fire),
        .cpl_data (cpl_data)
    );

    assign wd_arm = {q.wait_cpl, q.wait_ack};

    for (genvar g = 0; g < N_WAIT; g++) begin : g_wdog
        mbus_wdog #(.LIMIT(TIMEOUT)) u_wdog (
            .clk      (clk),
            .rst_n    (rst_n),
            .arm_i    (wd_arm[g]),
            .expire_o (wd_expire[g])
        );
    end

    always_comb begin
        req_ready = (q.state == ST_IDLE) && !q.wait_ack
                    && (req_kind != KIND_BAD)
                    && !((req_kind == KIND_RD) && q.wait_cpl);
        accept = req_valid && req_ready;
        unique case (req_kind)
            KIND_RD:     tx_cmd = CMD_RD;
            KIND_WR_UNC: tx_cmd = CMD_WR_UNC;
            KIND_WR_COM: tx_cmd = CMD_WR_COM;
            default:     tx_cmd = CMD_NOP;
        endcase
    end

    always_comb begin
        d           = q;
        d.bus       = '0;
        d.rsp_valid = 1'b0;

        case (q.state)
            ST_IDLE: begin
                if (accept) begin
                    d.addr  = req_addr;
                    d.wdata = req_wdata;
                    d.is_wr = (req_kind != KIND_RD);
                    d.bus   = {tx_cmd, req_addr[ADDR_W-1 -: HI_W]};
                    d.state = ST_BEAT1;
                    if (req_kind == KIND_WR_COM) d.wait_ack = 1'b1;
                    if (req_kind == KIND_RD)     d.wait_cpl = 1'b1;
                end
            end
            ST_BEAT1: begin
                d.bus   = q.addr[BEAT_W-1:0];
                d.state = q.is_wr ? ST_BEAT2 : ST_IDLE;
            end
            ST_BEAT2: begin
                d.bus   = q.wdata;
                d.state = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase

        if (q.wait_ack && ack_fire) d.wait_ack = 1'b0;
        if (q.wait_cpl && cpl_fire) begin
            d.wait_cpl  = 1'b0;
            d.rsp_valid = 1'b1;
            d.rsp_data  = cpl_data;
        end
        if (wd_expire[0] && !ack_fire) begin
            d.wait_ack = 1'b0;
            d.err      = 1'b1;
        end
        if (wd_expire[1] && !cpl_fire) begin
            d.wait_cpl = 1'b0;
            d.err      = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mb_out      = q.bus;
    assign rsp_valid   = q.rsp_valid;
    assign rsp_data    = q.rsp_data;
    assign err_timeout = q.err;

    assert_stall_after_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q.wait_ack |-> !req_ready);

    assert_single_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.wait_cpl && req_kind == KIND_RD) |-> !req_ready);

    assert_bad_kind_refused_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_kind == KIND_BAD) |-> !req_ready);

    assert_nop_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE && !accept) |=> (mb_out == '0));

    assert_first_beat_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_BEAT1) |-> (mb_out[BEAT_W-1 -: CMD_W] == CMD_RD
                                 || mb_out[BEAT_W-1 -: CMD_W] == CMD_WR_UNC
                                 || mb_out[BEAT_W-1 -: CMD_W] == CMD_WR_COM));

    assert_rsp_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |=> err_timeout);
endmodule

// File: tb/mbus_initiator_bench.sv
`timescale 1ns/1ps
module mbus_initiator_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = 2'd0;
    logic [11:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_data;
    logic [7:0]  mb_out;
    logic [7:0]  mb_in = '0;
    logic        err_timeout;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    mbus_initiator u_mbus_initiator (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mb_out(mb_out),
        .mb_in(mb_in), .err_timeout(err_timeout)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] cmd_of(input logic [1:0] kind);
        case (kind)
            2'd0:    return 4'h3;
            2'd1:    return 4'h1;
            2'd2:    return 4'h2;
            default: return 4'h0;
        endcase
    endfunction

    // hand over one request; returns just after the accepting edge
    task automatic issue(input logic [1:0] kind, input logic [11:0] addr, input logic [7:0] data);
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_addr = addr; req_wdata = data;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    // R2 / R4: issue and check every beat of the frame
    task automatic send_frame(input logic [1:0] kind, input logic [11:0] addr,
                              input logic [7:0] data, input string tag);
        issue(kind, addr, data);
        @(negedge clk); chk({tag, " R2 beat0"}, mb_out, {cmd_of(kind), addr[11:8]});
        @(negedge clk); chk({tag, " R2 beat1"}, mb_out, addr[7:0]);
        if (kind != 2'd0) begin
            @(negedge clk); chk({tag, " R2 beat2"}, mb_out, data);
            if (kind == 2'd1) chk({tag, " R4 ready at last beat"}, req_ready, 1'b1);
        end
    endtask

    task automatic send_ack();
        @(negedge clk); mb_in = 8'h50;
        #1 chk("R5 ready low during ack beat", req_ready, 1'b0);
        @(negedge clk); mb_in = 8'h00;
        #1 chk("R5 ready back after ack", req_ready, 1'b1);
    endtask

    task automatic send_cpl(input logic [7:0] data, input bit expect_rsp, input string tag);
        @(negedge clk); mb_in = 8'h40;
        @(negedge clk); mb_in = data;
        @(negedge clk); mb_in = 8'h00;
        chk({tag, " rsp_valid"}, rsp_valid, expect_rsp);
        if (expect_rsp) chk({tag, " R6 rsp_data"}, rsp_data, data);
        @(negedge clk); chk({tag, " rsp pulse ends"}, rsp_valid, 1'b0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req_valid = 1'b0; req_kind = 2'd0; mb_in = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 bus idle", mb_out, 8'h00);
        chk("R1 ready", req_ready, 1'b1);
        chk("R1 rsp_valid", rsp_valid, 1'b0);
        chk("R1 err", err_timeout, 1'b0);
    endtask

    task automatic t_read_frame();
        send_frame(2'd0, 12'hA5C, 8'h00, "read");
        @(negedge clk); chk("R3 NOP after read", mb_out, 8'h00);
        send_cpl(8'h3C, 1'b1, "R6 read data");
    endtask

    task automatic t_write_uncommitted();
        send_frame(2'd1, 12'h123, 8'h9E, "wr_unc");
        @(negedge clk); chk("R3 NOP after write", mb_out, 8'h00);
        @(negedge clk); chk("R3 NOP idle", mb_out, 8'h00);
    endtask

    task automatic t_commit_stall();
        send_frame(2'd2, 12'hFFF, 8'h01, "wr_com");
        repeat (3) begin
            @(negedge clk);
            req_kind = 2'd0; #1 chk("R5 read stalled", req_ready, 1'b0);
            req_kind = 2'd1; #1 chk("R5 write stalled", req_ready, 1'b0);
        end
        req_kind = 2'd1;
        send_ack();
    endtask

    task automatic t_read_block();
        send_frame(2'd0, 12'h010, 8'h00, "read2");
        @(negedge clk);
        req_kind = 2'd0; #1 chk("R7 second read held", req_ready, 1'b0);
        req_kind = 2'd1; #1 chk("R7 write allowed", req_ready, 1'b1);
        send_frame(2'd1, 12'h011, 8'hC3, "R7 write during read");
        send_cpl(8'h77, 1'b1, "R7 completion");
        req_kind = 2'd0; #1 chk("R7 read accepted again", req_ready, 1'b1);
    endtask

    task automatic t_cpl_not_ack();
        send_frame(2'd0, 12'h200, 8'h00, "read3");
        send_frame(2'd2, 12'h201, 8'h44, "R8 commit during read");
        send_cpl(8'h50, 1'b1, "R8 ack-like data");
        req_kind = 2'd1; #1 chk("R8 stall kept after ack-like data", req_ready, 1'b0);
        send_ack();
        send_cpl(8'h12, 1'b0, "R8 unsolicited completion");
    endtask

    task automatic t_bad_kind();
        @(negedge clk); req_valid = 1'b1; req_kind = 2'd3;
        repeat (3) begin
            @(negedge clk);
            chk("R10 kind3 not ready", req_ready, 1'b0);
            chk("R10 nothing sent", mb_out, 8'h00);
        end
        req_valid = 1'b0; req_kind = 2'd0;
    endtask

    task automatic t_timeout();
        chk("R9 err clear before", err_timeout, 1'b0);
        issue(2'd2, 12'h0AA, 8'h55);
        repeat (63) @(posedge clk);
        @(negedge clk);
        req_kind = 2'd0; #1;
        chk("R9 still waiting at 63", req_ready, 1'b0);
        chk("R9 err low at 63", err_timeout, 1'b0);
        @(negedge clk); #1;
        chk("R9 err at 64", err_timeout, 1'b1);
        chk("R9 stall released", req_ready, 1'b1);
        send_frame(2'd0, 12'h0AB, 8'h00, "R9 read after timeout");
        send_cpl(8'hE1, 1'b1, "R9 completion after timeout");
        chk("R9 err sticky", err_timeout, 1'b1);
        do_reset();
        @(negedge clk); chk("R1 err cleared by reset", err_timeout, 1'b0);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_read_frame();
        t_write_uncommitted();
        t_commit_stall();
        t_read_block();
        t_cpl_not_ack();
        t_bad_kind();
        t_timeout();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule